// File: doc/BRIEF.md
# Paged Memory Address Translator

This block sits on an 8-bit processor bus that sees a 64 KB logical space and turns each access into a physical address in a 1 MB space. The logical space is cut into sixteen 4 KB pages. The top four logical address bits pick one of sixteen 8-bit page entries. The low twelve bits pass through unchanged as the page offset. Software reprograms the entries through a write-only register window that occupies the upper half of the I/O page.

Bit 7 of an entry does not extend the address. It marks the page as write-protected. The remaining seven bits reach 512 KB of RAM, built from sixteen 32 KB devices. Entry bits 6..3 choose one device through a one-hot, active-low chip select. Entry bits 2..0 become the upper three address bits inside that device.

The two highest logical pages hold I/O and a mirrored boot ROM. They bypass translation and never select RAM. Every RAM strobe and every table write is qualified by the bus E phase, so nothing happens outside the valid data phase of a bus cycle.

Top module: `pageMapper`

## Requirements
- R1: After reset, entry i holds the value i with write protect clear, so logical page i (0..13) maps to physical page i.
- R2: For a logical address A, physPage equals the entry selected by A[15:12], and ramAddr equals {entry[2:0], A[11:0]}.
- R3: In a translated page with busE high, exactly one chip select is low: ramCsN[n], where n is entry[6:3].
- R4: While busE is low, all ramCsN bits, ramOeN and ramWeN are high.
- R5: A bus write (cpuRnw = 0) with busE high at any address from 0xE800 to 0xEFFF loads cpuData into entry A[3:0] at the next rising clk edge. The new value is visible from the following cycle.
- R6: A window access with busE low, a window read (cpuRnw = 1), or a write at 0xE000 to 0xE7FF leaves every entry unchanged.
- R7: When entry bit 7 is set, a write to that page keeps ramWeN high and raises protFault. A read of that page still drives ramOeN low.
- R8: Any access to 0xE000 to 0xFFFF keeps all ramCsN bits, ramOeN and ramWeN high. This includes writes to the register window.
- R9: In a translated page with busE high, a read drives ramOeN low and ramWeN high. A write to an unprotected page drives ramWeN low and ramOeN high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that updates the page table |
| rstN | input | 1 | Active-low asynchronous reset; loads the identity map |
| cpuAddr | input | 16 | Logical address from the processor |
| cpuData | input | 8 | Write data from the processor |
| cpuRnw | input | 1 | 1 = read, 0 = write |
| busE | input | 1 | Bus data-phase qualifier, active high |
| physPage | output | 8 | Entry selected by the current logical page |
| ramAddr | output | 15 | Address inside the selected 32 KB device |
| ramCsN | output | 16 | Active-low one-hot RAM device selects |
| ramOeN | output | 1 | Active-low RAM output enable |
| ramWeN | output | 1 | Active-low RAM write enable |
| protFault | output | 1 | High while a write hits a protected page |

## Verification
The identity map left by reset is swept over every translated page. This shows that the top address bits select the right entry and that entry bits 6..3 drive the right chip select. Entries are then programmed with patterns whose device field, in-device bits and protect bit all differ. This separates a swapped field from a correct one and exposes device select codes at the high end of the range. Accesses are repeated with busE low, with reads in the register window, and just below the window. These show that only a qualified write changes the table. Reads and writes to both system pages show that translation is bypassed there.

// File: rtl/pmPkg.sv
package pmPkg;
  typedef struct packed {
    logic tblWr;   // load a page entry this cycle
    logic ramSel;  // drive a RAM chip select
    logic rdEn;    // enable RAM output
    logic wrEn;    // enable RAM write
  } ctrlT;
endpackage

// File: rtl/pmCtrl.sv
module pmCtrl import pmPkg::*; #(
  parameter int PAGE_BITS      = 4,
  parameter int IO_PAGE        = 14,
  parameter int SYS_FIRST_PAGE = 14
) (
  input  logic [PAGE_BITS-1:0] pageIdx,
  input  logic                 winBit,
  input  logic                 cpuRnw,
  input  logic                 busE,
  input  logic                 wpBit,
  output ctrlT                 ctrl,
  output logic                 protFault
);
  logic sysPage, inWindow, ramCycle;

  always_comb begin
    sysPage   = pageIdx >= PAGE_BITS'(SYS_FIRST_PAGE);
    inWindow  = (pageIdx == PAGE_BITS'(IO_PAGE)) && winBit;
    ramCycle  = busE && !sysPage;
    ctrl.tblWr  = busE && !cpuRnw && inWindow;
    ctrl.ramSel = ramCycle;
    ctrl.rdEn   = ramCycle && cpuRnw;
    ctrl.wrEn   = ramCycle && !cpuRnw && !wpBit;
    protFault   = ramCycle && !cpuRnw && wpBit;
  end
endmodule

// File: rtl/pmData.sv
module pmData import pmPkg::*; #(
  parameter int PAGE_BITS     = 4,
  parameter int ENTRY_W       = 8,
  parameter int DEV_BITS      = 4,
  parameter int DEV_ADDR_BITS = 3,
  parameter int OFF_BITS      = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlT                              ctrl,
  input  logic [PAGE_BITS-1:0]              pageIdx,
  input  logic [PAGE_BITS-1:0]              regIdx,
  input  logic [ENTRY_W-1:0]                wrData,
  input  logic [OFF_BITS-1:0]               offset,
  output logic [ENTRY_W-1:0]                curEntry,
  output logic [DEV_ADDR_BITS+OFF_BITS-1:0] ramAddr,
  output logic [(1<<DEV_BITS)-1:0]          ramCsN,
  output logic                              ramOeN,
  output logic                              ramWeN
);
  localparam int NUM_PAGES = 1 << PAGE_BITS;
  localparam int NUM_DEV   = 1 << DEV_BITS;

  logic [ENTRY_W-1:0]  pageTbl [NUM_PAGES];
  logic [DEV_BITS-1:0] devIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAGES; i++) pageTbl[i] <= ENTRY_W'(i);
    end else if (ctrl.tblWr) begin
      pageTbl[regIdx] <= wrData;
    end
  end

  assign curEntry = pageTbl[pageIdx];
  assign devIdx   = curEntry[DEV_ADDR_BITS +: DEV_BITS];
  assign ramAddr  = {curEntry[DEV_ADDR_BITS-1:0], offset};
  assign ramOeN   = !ctrl.rdEn;
  assign ramWeN   = !ctrl.wrEn;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_devSel
    assign ramCsN[d] = !(ctrl.ramSel && (devIdx == DEV_BITS'(d)));
  end

  // R5: a qualified window write lands in the addressed entry
  a_r5_entry_written: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.tblWr |=> pageTbl[$past(regIdx)] == $past(wrData));
  // R3: never more than one device selected
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ramCsN));
  // R9: output enable and write enable never together
  a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramOeN && !ramWeN));
endmodule

// File: rtl/pageMapper.sv
module pageMapper import pmPkg::*; #(
  parameter int PAGE_BITS      = 4,
  parameter int OFF_BITS       = 12,
  parameter int ENTRY_W        = 8,
  parameter int DEV_BITS       = 4,
  parameter int DEV_ADDR_BITS  = 3,
  parameter int IO_PAGE        = 14,
  parameter int SYS_FIRST_PAGE = 14
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [PAGE_BITS+OFF_BITS-1:0]     cpuAddr,
  input  logic [ENTRY_W-1:0]                cpuData,
  input  logic                              cpuRnw,
  input  logic                              busE,
  output logic [ENTRY_W-1:0]                physPage,
  output logic [DEV_ADDR_BITS+OFF_BITS-1:0] ramAddr,
  output logic [(1<<DEV_BITS)-1:0]          ramCsN,
  output logic                              ramOeN,
  output logic                              ramWeN,
  output logic                              protFault
);
  localparam int ADDR_W = PAGE_BITS + OFF_BITS;

  ctrlT                 ctrl;
  logic [ENTRY_W-1:0]   curEntry;
  logic [PAGE_BITS-1:0] pageIdx;

  assign pageIdx  = cpuAddr[ADDR_W-1 -: PAGE_BITS];
  assign physPage = curEntry;

  pmCtrl #(
    .PAGE_BITS(PAGE_BITS), .IO_PAGE(IO_PAGE), .SYS_FIRST_PAGE(SYS_FIRST_PAGE)
  ) u_ctrl (
    .pageIdx  (pageIdx),
    .winBit   (cpuAddr[OFF_BITS-1]),
    .cpuRnw   (cpuRnw),
    .busE     (busE),
    .wpBit    (curEntry[ENTRY_W-1]),
    .ctrl     (ctrl),
    .protFault(protFault)
  );

  pmData #(
    .PAGE_BITS(PAGE_BITS), .ENTRY_W(ENTRY_W), .DEV_BITS(DEV_BITS),
    .DEV_ADDR_BITS(DEV_ADDR_BITS), .OFF_BITS(OFF_BITS)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .pageIdx (pageIdx),
    .regIdx  (cpuAddr[PAGE_BITS-1:0]),
    .wrData  (cpuData),
    .offset  (cpuAddr[OFF_BITS-1:0]),
    .curEntry(curEntry),
    .ramAddr (ramAddr),
    .ramCsN  (ramCsN),
    .ramOeN  (ramOeN),
    .ramWeN  (ramWeN)
  );

  // R4: no RAM strobe outside the E phase
  a_r4_idle_without_e: assert property (@(posedge clk) disable iff (!rstN)
    !busE |-> ((&ramCsN) && ramOeN && ramWeN));
  // R8: system pages never reach RAM
  a_r8_sys_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (pageIdx >= PAGE_BITS'(SYS_FIRST_PAGE)) |-> ((&ramCsN) && ramOeN && ramWeN));
  // R7: a protected write never strobes RAM
  a_r7_protect_blocks_we: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> ramWeN);
endmodule

// File: tb/test_pageMapper.sv
module test_pageMapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuRnw = 1'b1;
  logic        busE = 1'b0;
  logic [7:0]  physPage;
  logic [14:0] ramAddr;
  logic [15:0] ramCsN;
  logic        ramOeN, ramWeN, protFault;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageMapper i_pageMapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuRnw(cpuRnw), .busE(busE), .physPage(physPage), .ramAddr(ramAddr),
    .ramCsN(ramCsN), .ramOeN(ramOeN), .ramWeN(ramWeN), .protFault(protFault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expCs(input logic [7:0] ent);
    return ~(16'h1 << ent[6:3]);
  endfunction

  // drive one bus access at a falling edge, settle, then sample
  task automatic access(input logic [15:0] a, input logic rnw, input logic e,
                        input logic [7:0] d = 8'h00);
    @(negedge clk);
    cpuAddr = a; cpuRnw = rnw; busE = e; cpuData = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    busE = 1'b0; cpuRnw = 1'b1;
  endtask

  // check translation of a page through a read
  task automatic checkMap(input string req, input logic [3:0] pg, input logic [7:0] ent);
    logic [15:0] a;
    a = {pg, 12'h5A3};
    access(a, 1'b1, 1'b1);
    chk(req, physPage, ent);
    chk(req, ramAddr, {ent[2:0], 12'h5A3});
    chk(req, ramCsN, expCs(ent));
    chk(req, ramOeN, 1'b0);
    chk(req, ramWeN, 1'b1);
  endtask

  task automatic testReset();
    chk("R4 reset idle cs", ramCsN, 16'hFFFF);
    for (int p = 0; p < 14; p++) checkMap("R1 R2 R3 identity", 4'(p), 8'(p));
    idle();
  endtask

  task automatic testProgram();
    access(16'hE803, 1'b0, 1'b1, 8'h5A);   // entry 3 = 0x5A
    chk("R8 window write no cs", ramCsN, 16'hFFFF);
    idle();
    checkMap("R5 R2 R3 programmed", 4'h3, 8'h5A);
    chk("R2 ramAddr", ramAddr, 15'h25A3);
    access(16'h3ABC, 1'b0, 1'b1, 8'h00);
    chk("R9 write we low", ramWeN, 1'b0);
    chk("R9 write oe high", ramOeN, 1'b1);
    chk("R3 write cs", ramCsN, 16'hF7FF);
    chk("R7 no fault unprotected", protFault, 1'b0);
    idle();
    access(16'hEFF2, 1'b0, 1'b1, 8'h7F);   // mirror of window, entry 2
    idle();
    checkMap("R5 window top entry2", 4'h2, 8'h7F);
    chk("R3 top device", ramCsN, 16'h7FFF);
    idle();
  endtask

  task automatic testIgnored();
    access(16'h3123, 1'b1, 1'b0);
    chk("R4 E low cs", ramCsN, 16'hFFFF);
    chk("R4 E low oe", ramOeN, 1'b1);
    access(16'h3123, 1'b0, 1'b0);
    chk("R4 E low we", ramWeN, 1'b1);
    access(16'hE803, 1'b0, 1'b0, 8'h11);   // E low window write
    idle();
    checkMap("R6 E low write ignored", 4'h3, 8'h5A);
    access(16'hE803, 1'b1, 1'b1, 8'h22);   // window read
    idle();
    checkMap("R6 window read ignored", 4'h3, 8'h5A);
    access(16'hE7F4, 1'b0, 1'b1, 8'h33);   // just below the window
    idle();
    checkMap("R6 below window ignored", 4'h4, 8'h04);
    idle();
  endtask

  task automatic testProtect();
    access(16'hE805, 1'b0, 1'b1, 8'hC7);   // wp, device 8, hi 7
    idle();
    access(16'h5010, 1'b0, 1'b1);
    chk("R7 protected we high", ramWeN, 1'b1);
    chk("R7 fault raised", protFault, 1'b1);
    chk("R7 protected cs", ramCsN, 16'hFEFF);
    access(16'h5010, 1'b1, 1'b1);
    chk("R7 protected read oe", ramOeN, 1'b0);
    chk("R7 read no fault", protFault, 1'b0);
    chk("R7 physPage", physPage, 8'hC7);
    idle();
  endtask

  task automatic testSystem();
    access(16'hE123, 1'b1, 1'b1);
    chk("R8 io read cs", ramCsN, 16'hFFFF);
    chk("R8 io read oe", ramOeN, 1'b1);
    access(16'hF7FF, 1'b1, 1'b1);
    chk("R8 rom read cs", ramCsN, 16'hFFFF);
    chk("R8 rom read oe", ramOeN, 1'b1);
    access(16'hFFFF, 1'b0, 1'b1);
    chk("R8 rom write we", ramWeN, 1'b1);
    chk("R8 rom write cs", ramCsN, 16'hFFFF);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testProgram();
    testIgnored();
    testProtect();
    testSystem();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule